// File: doc/BRIEF.md
# Asynchronous Pseudo-SRAM Access Controller

This block sits on the host side of an asynchronous 16-bit pseudo-SRAM. It accepts one command at a time on a valid/ready port. A command is a single-word write, or a read of one to sixteen consecutive words. It turns each command into the chip-select, output-enable, write-enable and per-byte strobe sequences that the memory needs, and returns read words on a response port. Every memory timing is given in nanoseconds and converted to whole controller clocks, rounded up, from the clock period parameter.

A multi-word read uses the memory's page mode. The first word of a page waits the full random-access time. Later words change only the four low address bits and wait only the shorter page time. A page closes and the chip select goes high for at least the minimum gap in three cases: the request is done, the next word lies in a different sixteen-word page, or one more page step would keep chip select low longer than the open-time cap. Reading then resumes with a fresh full-time access. Writes drive the data bus only while write enable is low. One clock with chip select low and write enable high comes before the pulse and one comes after it.

The FSM states are IDLE, RD_ACC (full-time read access), RD_PAGE (page-step read access), WR_SETUP, WR_PULSE, WR_HOLD and CS_GAP. The transitions are as follows.
- IDLE→RD_ACC on a read command.
- IDLE→WR_SETUP on a write with a non-zero byte mask.
- IDLE→IDLE on a write with an empty mask, which is dropped.
- RD_ACC/RD_PAGE→RD_PAGE for a page step.
- RD_ACC/RD_PAGE→CS_GAP to close the page.
- WR_SETUP→WR_PULSE→WR_HOLD→CS_GAP.
- CS_GAP→RD_ACC when words remain, otherwise CS_GAP→IDLE.

Top module: `psram_ctrl`

## Requirements
- R1: After reset all memory strobes (chip select, output enable, write enable, both byte enables) are high, the data bus driver is off, cmd_ready is 1 and rsp_valid is 0.
- R2: A read returns the addressed word on rsp_data with rsp_valid high for one clock. The first word of a page is sampled only after chip select and output enable have been low for RC_CYC clocks.
- R3: cmd_be bit 0 enables the lower lane (data bits 7:0, mem_lb_n) and bit 1 the upper lane (bits 15:8, mem_ub_n). A disabled lane keeps its strobe high during the access and returns zero in rsp_data.
- R4: A write holds write enable low for at least WP_CYC clocks. It drives mem_dq_oe only while write enable is low, keeps output enable high, and has one clock of chip select low with write enable high before and after the pulse.
- R5: A write changes only the memory bytes whose cmd_be bit is set.
- R6: A write with cmd_be equal to 0 is accepted and dropped. Chip select stays high and the memory is unchanged.
- R7: Within one page, successive words keep mem_addr[22:4] fixed and step mem_addr[3:0] up by one, with each later word sampled after PC_CYC clocks.
- R8: cmd_len gives the number of words minus one (0 to 15). Responses come in address order and rsp_last is 1 only on the final word.
- R9: When the next word's address has low bits 0, the page closes. Chip select stays high for at least CP_CYC clocks and the next word uses a full access.
- R10: Chip select is never low for more than OPEN_CYC consecutive clocks. A read that would exceed this closes its page and resumes with a full access.
- R11: cmd_ready is high only in IDLE, so a command is accepted only when no earlier one is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this clock when high with cmd_valid |
| cmd_write | input | 1 | 1 = write one word, 0 = read |
| cmd_addr | input | 23 | Word address |
| cmd_len | input | 4 | Read length in words minus one |
| cmd_be | input | 2 | Byte-lane mask, bit 1 upper, bit 0 lower |
| cmd_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read word valid |
| rsp_data | output | 16 | Read word, disabled lanes zero |
| rsp_last | output | 1 | Final word of the command |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_addr | output | 23 | Memory word address |
| mem_dq_out | output | 16 | Data to the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
The embedded assertions check the following on every cycle: the write turnaround around each write pulse, the minimum pulse length, that upper address bits stay fixed and low bits step by one inside an open page, the open-time ceiling, that an empty-mask write leaves chip select high, and the single-command handshake. Only the bench scenarios can show data correctness. That covers lane masking on reads and writes, response order and the last flag, and the number of page closures a read makes at a sixteen-word boundary and under the open-time cap. A timing-checking memory model in the bench returns a poison value whenever an access is sampled too early.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_PAGE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_CS_GAP
    } pc_state_e;

    // Nanoseconds to whole clocks, rounded up, never below one clock.
    function automatic int ns2cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/psram_ctrl_tmr.sv
module psram_ctrl_tmr #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    AST_TMR_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && $past(cnt_q) != '0) |-> cnt_q == $past(cnt_q) - 1'b1); // R2
endmodule

// File: rtl/psram_ctrl_openwin.sv
module psram_ctrl_openwin #(
    parameter int MAX_CYC = 2000,
    localparam int CW = $clog2(MAX_CYC + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_active,
    output logic [CW-1:0] open_cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 open_cnt <= '0;
        else if (!cs_active)        open_cnt <= '0;
        else if (open_cnt != '1)    open_cnt <= open_cnt + 1'b1;
    end

    AST_OPEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cs_active |-> 32'(open_cnt) < MAX_CYC); // R10
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
    import psram_ctrl_pkg::*;
#(
    parameter int CLK_NS    = 10,
    parameter int T_RC_NS   = 60,
    parameter int T_PC_NS   = 20,
    parameter int T_WP_NS   = 50,
    parameter int T_CP_NS   = 10,
    parameter int T_OPEN_NS = 20000,
    parameter int AW        = 23,
    parameter int PAGE_BITS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic          cmd_write,
    input  logic [AW-1:0] cmd_addr,
    input  logic [3:0]    cmd_len,
    input  logic [1:0]    cmd_be,
    input  logic [15:0]   cmd_wdata,
    output logic          rsp_valid,
    output logic [15:0]   rsp_data,
    output logic          rsp_last,
    output logic          mem_cs_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic          mem_ub_n,
    output logic          mem_lb_n,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [15:0]   mem_dq_in
);
    localparam int RC_CYC   = ns2cyc(T_RC_NS, CLK_NS);
    localparam int PC_CYC   = ns2cyc(T_PC_NS, CLK_NS);
    localparam int WP_CYC   = ns2cyc(T_WP_NS, CLK_NS);
    localparam int CP_CYC   = ns2cyc(T_CP_NS, CLK_NS);
    localparam int OPEN_CYC = ns2cyc(T_OPEN_NS, CLK_NS);
    localparam int TMAX     = (RC_CYC > WP_CYC) ? RC_CYC : WP_CYC;
    localparam int TW       = $clog2(TMAX + 1);
    localparam int OCW      = $clog2(OPEN_CYC + 2);
    localparam int WCW      = $clog2(WP_CYC + 2);
    localparam int NLANE    = 2;

    pc_state_e     state_q, state_d;
    logic [AW-1:0] a_q;
    logic [4:0]    left_q;
    logic [1:0]    be_q;
    logic [15:0]   wd_q;
    logic          ld, tdone, smp, accept, cs_act;
    logic [TW-1:0] ld_val;
    logic [OCW-1:0] open_cnt;
    logic [15:0]   lane_mask;
    logic          page_fits, page_end;

    psram_ctrl_tmr #(.TW(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .done(tdone)
    );

    psram_ctrl_openwin #(.MAX_CYC(OPEN_CYC)) u_win (
        .clk(clk), .rst_n(rst_n), .cs_active(cs_act), .open_cnt(open_cnt)
    );

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign lane_mask[g*8 +: 8] = {8{be_q[g]}};
    end

    assign accept    = cmd_valid && cmd_ready;
    assign page_end  = (a_q[PAGE_BITS-1:0] == '1);
    assign page_fits = (32'(open_cnt) + 1 + PC_CYC) <= OPEN_CYC;

    // Next-state and timer load
    always_comb begin
        state_d = state_q;
        ld      = 1'b0;
        ld_val  = '0;
        smp     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (!cmd_write) begin
                        state_d = ST_RD_ACC;
                        ld = 1'b1; ld_val = TW'(RC_CYC - 1);
                    end else if (cmd_be != 2'b00) begin
                        state_d = ST_WR_SETUP;
                        ld = 1'b1; ld_val = '0;
                    end
                end
            end
            ST_RD_ACC, ST_RD_PAGE: begin
                if (tdone) begin
                    smp = 1'b1;
                    ld  = 1'b1;
                    if (left_q != 5'd1 && !page_end && page_fits) begin
                        state_d = ST_RD_PAGE; ld_val = TW'(PC_CYC - 1);
                    end else begin
                        state_d = ST_CS_GAP;  ld_val = TW'(CP_CYC - 1);
                    end
                end
            end
            ST_WR_SETUP: if (tdone) begin
                state_d = ST_WR_PULSE; ld = 1'b1; ld_val = TW'(WP_CYC - 1);
            end
            ST_WR_PULSE: if (tdone) begin
                state_d = ST_WR_HOLD; ld = 1'b1; ld_val = '0;
            end
            ST_WR_HOLD: if (tdone) begin
                state_d = ST_CS_GAP; ld = 1'b1; ld_val = TW'(CP_CYC - 1);
            end
            ST_CS_GAP: if (tdone) begin
                if (left_q != '0) begin
                    state_d = ST_RD_ACC; ld = 1'b1; ld_val = TW'(RC_CYC - 1);
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and command/response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            a_q       <= '0;
            left_q    <= '0;
            be_q      <= '0;
            wd_q      <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_last  <= 1'b0;
        end else begin
            state_q   <= state_d;
            rsp_valid <= smp;
            if (accept) begin
                a_q    <= cmd_addr;
                be_q   <= cmd_be;
                wd_q   <= cmd_wdata;
                left_q <= cmd_write ? 5'd0 : 5'({1'b0, cmd_len} + 5'd1);
            end
            if (smp) begin
                rsp_data <= mem_dq_in & lane_mask;
                rsp_last <= (left_q == 5'd1);
                a_q      <= a_q + 1'b1;
                left_q   <= left_q - 1'b1;
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        cmd_ready = (state_q == ST_IDLE);
        cs_act    = 1'b0;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (state_q)
            ST_RD_ACC, ST_RD_PAGE: begin cs_act = 1'b1; mem_oe_n = 1'b0; end
            ST_WR_SETUP, ST_WR_HOLD: cs_act = 1'b1;
            ST_WR_PULSE: begin cs_act = 1'b1; mem_we_n = 1'b0; mem_dq_oe = 1'b1; end
            default: ;
        endcase
        mem_cs_n   = !cs_act;
        mem_lb_n   = !(cs_act && be_q[0]);
        mem_ub_n   = !(cs_act && be_q[1]);
        mem_addr   = a_q;
        mem_dq_out = wd_q;
    end

    // Checking logic: length of the current write pulse
    logic [WCW-1:0] we_lo_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          we_lo_cnt <= '0;
        else if (mem_we_n)                   we_lo_cnt <= '0;
        else if (we_lo_cnt != '1)            we_lo_cnt <= we_lo_cnt + 1'b1;
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        $rose(rst_n) |-> mem_cs_n && mem_we_n && !mem_dq_oe); // R1
    AST_WE_SETUP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(!mem_cs_n) && $past(!mem_dq_oe) && mem_oe_n); // R4
    AST_WE_HOLD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !mem_cs_n && !mem_dq_oe); // R4
    AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> 32'($past(we_lo_cnt)) >= WP_CYC - 1); // R4
    AST_PAGE_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n && $past(!mem_oe_n) && $past(!mem_cs_n))
            |-> mem_addr[AW-1:PAGE_BITS] == $past(mem_addr[AW-1:PAGE_BITS])); // R7
    AST_PAGE_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n && $past(!mem_oe_n) && mem_addr != $past(mem_addr))
            |-> mem_addr[PAGE_BITS-1:0] == $past(mem_addr[PAGE_BITS-1:0]) + 1'b1); // R7
    AST_EMPTY_WRITE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_write && cmd_be == 2'b00) |=> mem_cs_n && cmd_ready); // R6
    AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !(cmd_write && cmd_be == 2'b00)) |=> !cmd_ready); // R11
endmodule

// File: tb/psram_ctrl_tb.sv
module psram_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RC_C = 6, PC_C = 2, WP_C = 5, CP_C = 1, OE_C = 3, OPEN_C = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_write = 1'b0;
    logic [22:0] cmd_addr = '0;
    logic [3:0]  cmd_len = '0;
    logic [1:0]  cmd_be = '0;
    logic [15:0] cmd_wdata = '0;
    logic cmd_ready, rsp_valid, rsp_last;
    logic [15:0] rsp_data;
    logic mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;
    logic [22:0] mem_addr;
    logic [15:0] mem_dq_out;
    logic [15:0] model_dq = 16'hBAD0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psram_ctrl #(.CLK_NS(CLK_PERIOD), .T_OPEN_NS(OPEN_C * CLK_PERIOD)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_be(cmd_be),
        .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_last(rsp_last), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(model_dq)
    );

    function automatic logic [15:0] init_word(input int a);
        return 16'(a * 16'h9E37) ^ 16'h5A3C;
    endfunction

    // ---------------- behavioural memory with timing checks ----------------
    logic [15:0] mmem [int];
    int viol = 0, max_run = 0, cs_falls = 0;
    int row_age = 0, col_age = 0, oe_age = 0, cs_run = 0, hi_run = 0, we_run = 0;
    logic p_cs = 1'b0, p_oe = 1'b0, p_we = 1'b0, p_dqoe = 1'b0;
    logic [22:0] p_addr = '0;
    logic [15:0] w_data = '0;
    logic [1:0]  w_lanes = '0;

    function automatic logic [15:0] mrd(input int a);
        return mmem.exists(a) ? mmem[a] : init_word(a);
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            logic cs, oe, we;
            logic [15:0] w;
            cs = !mem_cs_n; oe = !mem_oe_n; we = !mem_we_n;
            if (cs && !p_cs) begin
                cs_falls++;
                if (hi_run < CP_C) viol++;
                row_age = 1; col_age = 1; cs_run = 1;
            end else if (cs) begin
                cs_run++;
                row_age = (mem_addr[22:4] != p_addr[22:4]) ? 1 : row_age + 1;
                col_age = (mem_addr[3:0]  != p_addr[3:0])  ? 1 : col_age + 1;
            end else begin
                hi_run = p_cs ? 1 : hi_run + 1;
            end
            if (cs && cs_run > max_run) max_run = cs_run;
            if (cs_run > OPEN_C) viol++;
            oe_age = !oe ? 0 : (p_oe ? oe_age + 1 : 1);
            if (we) begin
                we_run = p_we ? we_run + 1 : 1;
                if (!p_we && (!p_cs || p_dqoe)) viol++;
                w_data = mem_dq_out; w_lanes = {!mem_ub_n, !mem_lb_n};
            end else if (p_we) begin
                if (we_run < WP_C) viol++;
                w = mrd(int'(p_addr));
                if (w_lanes[0]) w[7:0]  = w_data[7:0];
                if (w_lanes[1]) w[15:8] = w_data[15:8];
                mmem[int'(p_addr)] = w;
            end
            if (mem_dq_oe && (oe || !we)) viol++;
            if (we && oe) viol++;
            if (cs && oe && !we && row_age >= RC_C && col_age >= PC_C && oe_age >= OE_C) begin
                w = mrd(int'(mem_addr));
                model_dq <= {mem_ub_n ? 8'hEE : w[15:8], mem_lb_n ? 8'hEE : w[7:0]};
            end else begin
                model_dq <= 16'hBAD0;
            end
            p_cs = cs; p_oe = oe; p_we = we; p_dqoe = mem_dq_oe; p_addr = mem_addr;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct packed { logic [15:0] d; logic l; } exp_t;
    exp_t exp_q[$];
    logic [15:0] shadow [int];
    int n_chk = 0, n_fail = 0, m_chk = 0, m_fail = 0;
    bit wd_fired = 1'b0;

    function automatic logic [15:0] srd(input int a);
        return shadow.exists(a) ? shadow[a] : init_word(a);
    endfunction

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            m_chk++;
            if (exp_q.size() == 0) begin
                m_fail++;
                $display("FAIL R8 unexpected response actual=%h expected=none", rsp_data);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (rsp_data !== e.d || rsp_last !== e.l) begin
                    m_fail++;
                    $display("FAIL R2/R3/R8 response actual=%h last=%0b expected=%h last=%0b",
                             rsp_data, rsp_last, e.d, e.l);
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_cmd(input bit wr, input int a, input int nw, input logic [1:0] be,
                           input logic [15:0] wd, input int exp_falls, input string req);
        int f0;
        if (wr) begin
            logic [15:0] w;
            w = srd(a);
            if (be[0]) w[7:0]  = wd[7:0];
            if (be[1]) w[15:8] = wd[15:8];
            shadow[a] = w;
        end else begin
            for (int i = 0; i < nw; i++) begin
                exp_t e;
                e.d = srd(a + i) & {{8{be[1]}}, {8{be[0]}}};
                e.l = (i == nw - 1);
                exp_q.push_back(e);
            end
        end
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        f0 = cs_falls;
        cmd_valid = 1'b1; cmd_write = wr; cmd_addr = 23'(a);
        cmd_len = 4'(nw - 1); cmd_be = be; cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!(cmd_ready && exp_q.size() == 0)) @(negedge clk);
        check(cs_falls - f0 == exp_falls, req, cs_falls - f0, exp_falls);
    endtask

    task automatic report;
        int tot, bad;
        tot = n_chk + m_chk + (wd_fired ? 1 : 0);
        bad = n_fail + m_fail + (wd_fired ? 1 : 0);
        $display("%0d/%0d checks passed", tot - bad, tot);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        wd_fired = 1'b1;
        $display("FAIL watchdog actual=timeout expected=completion");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(mem_cs_n && mem_oe_n && mem_we_n, "R1 strobes", {mem_cs_n, mem_oe_n, mem_we_n}, 7);
        check(mem_ub_n && mem_lb_n && !mem_dq_oe, "R1 lanes", {mem_ub_n, mem_lb_n, mem_dq_oe}, 6);
        check(cmd_ready && !rsp_valid, "R1 handshake", {cmd_ready, rsp_valid}, 2);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(mem_cs_n && cmd_ready, "R1 idle after reset", {mem_cs_n, cmd_ready}, 3);

        run_cmd(1'b0, 'h000123, 1, 2'b11, '0, 1, "R2 single read");
        run_cmd(1'b0, 'h000124, 1, 2'b01, '0, 1, "R3 lower lane read");
        run_cmd(1'b0, 'h000125, 1, 2'b10, '0, 1, "R3 upper lane read");
        run_cmd(1'b1, 'h000200, 1, 2'b11, 16'hCAFE, 1, "R4 full write");
        run_cmd(1'b1, 'h000200, 1, 2'b10, 16'h1234, 1, "R5 upper byte write");
        run_cmd(1'b1, 'h000200, 1, 2'b01, 16'hAB77, 1, "R5 lower byte write");
        run_cmd(1'b1, 'h000200, 1, 2'b00, 16'h0000, 0, "R6 empty-mask write");
        run_cmd(1'b0, 'h000200, 1, 2'b11, '0, 1, "R5 R6 read back");
        run_cmd(1'b0, 'h000310, 4, 2'b11, '0, 1, "R7 R8 page read");
        run_cmd(1'b0, 'h00041E, 4, 2'b11, '0, 2, "R9 page boundary split");
        run_cmd(1'b0, 'h000500, 16, 2'b11, '0, 4, "R10 open-time split");
        run_cmd(1'b0, 'h000602, 2, 2'b10, '0, 1, "R3 R8 masked page read");
        run_cmd(1'b1, 'h00060F, 1, 2'b01, 16'h00A5, 1, "R5 write at page end");
        run_cmd(1'b0, 'h00060E, 3, 2'b11, '0, 2, "R9 R5 read across boundary");

        check(viol == 0, "R4 R10 memory timing violations", viol, 0);
        check(max_run <= OPEN_C, "R10 longest chip-select run", max_run, OPEN_C);
        check(max_run == OPEN_C, "R10 open window used in full", max_run, OPEN_C);
        report();
        $finish;
    end
endmodule